// File: doc/BRIEF.md
# Macroblock Block Reorder Buffer

This block sits in front of a deblocking edge filter in a video pipeline. One 4:2:0 macroblock is made of 24 blocks of 4x4 samples. There are sixteen luma blocks in a 4x4 grid, then four Cb blocks and four Cr blocks in 2x2 grids. The blocks reach the input as a stream, one whole block (16 samples of 8 bits) per beat, under a valid/ready handshake. Luma blocks arrive in a nested Z order, with each 2x2 quadrant scanned in Z and the quadrants also taken in Z. All chroma blocks follow in ascending order. The block writes each arriving block into local storage at its raster position. It then streams the macroblock out in raster numbering, tagging each block with its number and its component.

Storage holds two macroblock banks. One bank can fill while the other drains, so a downstream filter that keeps pace never stalls the input. The input is held off only when both banks hold a complete macroblock that has not been read.

Write side FSM states: `WR_FILL` accepts blocks into the current bank. `WR_WAIT` holds off the input because the next bank is still unread. Transitions:
- `WR_FILL`->`WR_WAIT`: the last block is taken and the other bank is full.
- `WR_WAIT`->`WR_FILL`: the awaited bank is released.

Read side FSM states: `RD_IDLE` has nothing complete to send. `RD_SEND` presents blocks. Transitions:
- `RD_IDLE`->`RD_SEND`: the read bank becomes full.
- `RD_SEND`->`RD_IDLE`: the last block is handed over and the other bank is not full.
- `RD_SEND` stays in `RD_SEND` and moves to the other bank when that bank is already full.

Top module: `mb_block_reorder`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_last` is 0.
- R2: The luma block accepted at arrival position p (0..15) is emitted with `out_idx` equal to the raster number at position p of the list 0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15. Its 128-bit payload is emitted unchanged, with sample k at bits [8k+7:8k].
- R3: Chroma blocks at arrival positions 16..23 are emitted with `out_idx` equal to their arrival position and an unchanged payload.
- R4: `out_comp` is 0 for indices 0..15 (luma), 1 for 16..19 (Cb) and 2 for 20..23 (Cr).
- R5: Within a macroblock, blocks leave in ascending `out_idx` order, from 0 to 23.
- R6: `out_last` is 1 exactly when a presented block has `out_idx` 23.
- R7: While `out_valid` is 1 and `out_ready` is 0, the block presented on the output holds stable until it is taken.
- R8: Two whole macroblocks (48 blocks) are accepted with no output taken. After that, `in_ready` stays 0 until the first macroblock is fully read.
- R9: With an empty buffer, the 24 blocks of a macroblock are accepted on consecutive cycles without `in_ready` falling.
- R10: With `out_ready` held at 1, the 24 blocks of a macroblock are presented on consecutive cycles with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An input block is offered |
| in_ready | output | 1 | The buffer can take a block |
| in_data | input | SAMPLE_W*BLK_SAMPLES | One 4x4 block, sample k at bits [8k+7:8k] |
| out_valid | output | 1 | An output block is presented |
| out_ready | input | 1 | The consumer takes the block |
| out_data | output | SAMPLE_W*BLK_SAMPLES | Payload of the presented block |
| out_idx | output | 5 | Raster block number, 0..23 |
| out_comp | output | 2 | Component: 0 luma, 1 Cb, 2 Cr |
| out_last | output | 1 | Final block of the macroblock |

## Verification
A wrong slot translation shows up on the first output beat of the damaged position: the payload there belongs to a different arrival position, although the index sequence looks normal. A stuck or mis-toggled bank flag shows up at macroblock boundaries. Either `in_ready` falls one macroblock too early or too late, or the second macroblock drains stale payloads on its very first beat. A counter or last-flag fault breaks the index step or the position of `out_last` within one macroblock.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    localparam int MB_BLOCKS   = 24;
    localparam int LUMA_BLOCKS = 16;
    localparam int CB_BLOCKS   = 4;
    localparam int BANKS       = 2;
    localparam int IDX_W       = $clog2(MB_BLOCKS);

    typedef logic [IDX_W-1:0] blk_idx_t;

    typedef enum logic [1:0] {
        COMP_Y  = 2'd0,
        COMP_CB = 2'd1,
        COMP_CR = 2'd2
    } comp_e;

    localparam blk_idx_t LAST_IDX = blk_idx_t'(MB_BLOCKS - 1);
    localparam blk_idx_t CB_BASE  = blk_idx_t'(LUMA_BLOCKS);
    localparam blk_idx_t CR_BASE  = blk_idx_t'(LUMA_BLOCKS + CB_BLOCKS);
endpackage

// File: rtl/mbr_slot_map.sv
module mbr_slot_map
    import mbr_pkg::*;
(
    input  blk_idx_t arr_idx,
    output blk_idx_t raster_idx
);
    // Nested Z over a 4x4 grid: exchanging the two middle bits of the
    // arrival position yields the raster number. Chroma passes straight.
    always_comb begin
        raster_idx = arr_idx;
        if (arr_idx < CB_BASE) begin
            raster_idx[1] = arr_idx[2];
            raster_idx[2] = arr_idx[1];
        end
    end
endmodule

// File: rtl/mbr_wr_ctrl.sv
module mbr_wr_ctrl
    import mbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BANKS-1:0] bank_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             wr_bank,
    output blk_idx_t         wr_arr,
    output logic             wr_done
);
    typedef enum logic {WR_FILL, WR_WAIT} wr_state_e;

    wr_state_e state;
    blk_idx_t  cnt;
    logic      bank;
    logic      accept;

    assign accept = in_valid && (state == WR_FILL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_FILL;
            cnt   <= '0;
            bank  <= 1'b0;
        end else begin
            unique case (state)
                WR_FILL: begin
                    if (accept) begin
                        if (cnt == LAST_IDX) begin
                            cnt  <= '0;
                            bank <= ~bank;
                            if (bank_full[~bank]) state <= WR_WAIT;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                WR_WAIT: begin
                    if (!bank_full[bank]) state <= WR_FILL;
                end
            endcase
        end
    end

    always_comb begin
        in_ready = (state == WR_FILL);
        wr_en    = accept;
        wr_done  = accept && (cnt == LAST_IDX);
        wr_bank  = bank;
        wr_arr   = cnt;
    end
endmodule

// File: rtl/mbr_rd_ctrl.sv
module mbr_rd_ctrl
    import mbr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_ready,
    input  logic [BANKS-1:0] bank_full,
    output logic             out_valid,
    output logic             out_last,
    output logic             rd_bank,
    output blk_idx_t         rd_slot,
    output logic             rd_release
);
    typedef enum logic {RD_IDLE, RD_SEND} rd_state_e;

    rd_state_e state;
    blk_idx_t  cnt;
    logic      bank;
    logic      take;

    assign take = out_ready && (state == RD_SEND);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
            cnt   <= '0;
            bank  <= 1'b0;
        end else begin
            unique case (state)
                RD_IDLE: begin
                    if (bank_full[bank]) state <= RD_SEND;
                end
                RD_SEND: begin
                    if (take) begin
                        if (cnt == LAST_IDX) begin
                            cnt  <= '0;
                            bank <= ~bank;
                            if (!bank_full[~bank]) state <= RD_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_comb begin
        out_valid  = (state == RD_SEND);
        out_last   = (state == RD_SEND) && (cnt == LAST_IDX);
        rd_release = take && (cnt == LAST_IDX);
        rd_bank    = bank;
        rd_slot    = cnt;
    end
endmodule

// File: rtl/mbr_store.sv
module mbr_store
    import mbr_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  blk_idx_t         wr_slot,
    input  logic [BLK_W-1:0] wr_data,
    input  logic             rd_bank,
    input  blk_idx_t         rd_slot,
    output logic [BLK_W-1:0] rd_data
);
    logic [BLK_W-1:0] bank_rd [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [BLK_W-1:0] mem [MB_BLOCKS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) mem[wr_slot] <= wr_data;
        end

        assign bank_rd[b] = mem[rd_slot];
    end

    assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/mb_block_reorder.sv
module mb_block_reorder
    import mbr_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int BLK_SAMPLES = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    output logic                            in_ready,
    input  logic [SAMPLE_W*BLK_SAMPLES-1:0] in_data,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [SAMPLE_W*BLK_SAMPLES-1:0] out_data,
    output logic [IDX_W-1:0]                out_idx,
    output logic [1:0]                      out_comp,
    output logic                            out_last
);
    localparam int BLK_W = SAMPLE_W * BLK_SAMPLES;

    logic [BANKS-1:0] bank_full;
    logic             wr_en, wr_bank, wr_done;
    logic             rd_bank, rd_release;
    blk_idx_t         wr_arr, wr_slot, rd_slot;
    comp_e            comp;

    mbr_wr_ctrl u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .bank_full(bank_full),
        .in_ready (in_ready),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_arr   (wr_arr),
        .wr_done  (wr_done)
    );

    mbr_slot_map u_map (
        .arr_idx   (wr_arr),
        .raster_idx(wr_slot)
    );

    mbr_store #(.BLK_W(BLK_W)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_bank(wr_bank),
        .wr_slot(wr_slot),
        .wr_data(in_data),
        .rd_bank(rd_bank),
        .rd_slot(rd_slot),
        .rd_data(out_data)
    );

    mbr_rd_ctrl u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_ready (out_ready),
        .bank_full (bank_full),
        .out_valid (out_valid),
        .out_last  (out_last),
        .rd_bank   (rd_bank),
        .rd_slot   (rd_slot),
        .rd_release(rd_release)
    );

    // A bank is set by the writer only while empty and cleared by the
    // reader only while full, so both never target the same bank at once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_full <= '0;
        end else begin
            if (wr_done)    bank_full[wr_bank] <= 1'b1;
            if (rd_release) bank_full[rd_bank] <= 1'b0;
        end
    end

    always_comb begin
        if (rd_slot < CB_BASE)      comp = COMP_Y;
        else if (rd_slot < CR_BASE) comp = COMP_CB;
        else                        comp = COMP_CR;
        out_comp = comp;
        out_idx  = rd_slot;
    end
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker
    import mbr_pkg::*;
#(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [BLK_W-1:0] out_data,
    input logic [IDX_W-1:0] out_idx,
    input logic [1:0]       out_comp,
    input logic             out_last
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_idx)); // R7

    AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (out_idx == LAST_IDX))); // R6

    AST_COMP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_comp == ((out_idx < CB_BASE) ? 2'd0 :
                                    (out_idx < CR_BASE) ? 2'd1 : 2'd2))); // R4

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_last |=> out_valid && (out_idx == $past(out_idx) + 1'b1)); // R5

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_idx <= LAST_IDX); // R5

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_last); // R1
endmodule

bind mb_block_reorder mbr_checker #(.BLK_W(SAMPLE_W*BLK_SAMPLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_idx  (out_idx),
    .out_comp (out_comp),
    .out_last (out_last)
);

// File: tb/sim_mb_block_reorder.sv
`timescale 1ns/1ps
module sim_mb_block_reorder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_data;
    logic [4:0]   out_idx;
    logic [1:0]   out_comp;
    logic         out_last;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    mb_block_reorder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_idx(out_idx), .out_comp(out_comp),
        .out_last(out_last)
    );

    int luma_order [16] = '{0,1,4,5,2,3,6,7,8,9,12,13,10,11,14,15};

    function automatic logic [127:0] payload(int mb, int pos);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) v[8*k +: 8] = 8'(mb*7 + pos*11 + k*3);
        return v;
    endfunction

    function automatic int arrival_of(int raster);
        if (raster >= 16) return raster;
        for (int p = 0; p < 16; p++) if (luma_order[p] == raster) return p;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_mb(input int mb, input bit want_no_stall);
        int stalls = 0;
        for (int p = 0; p < 24; p++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = payload(mb, p);
            while (!in_ready) begin
                stalls++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        if (want_no_stall) chk(stalls == 0, "R9 input stall cycles", 128'(stalls), 128'd0);
    endtask

    task automatic collect_mb(input int mb, input bit stall);
        for (int r = 0; r < 24; r++) begin
            @(negedge clk);
            if (stall && (r % 3 == 0)) begin
                logic [127:0] d0;
                logic [4:0]   i0;
                out_ready = 1'b0;
                while (!out_valid) @(negedge clk);
                d0 = out_data;
                i0 = out_idx;
                @(negedge clk);
                chk(out_valid && out_data == d0 && out_idx == i0, "R7 hold under backpressure",
                    {out_idx, out_data[122:0]}, {i0, d0[122:0]});
            end
            out_ready = 1'b1;
            if (r == 0 || stall) begin
                while (!out_valid) @(negedge clk);
            end else begin
                chk(out_valid, "R10 gapless drain", 128'(out_valid), 128'd1);
            end
            chk(out_idx == 5'(r), "R5 index order", 128'(out_idx), 128'(r));
            chk(out_data == payload(mb, arrival_of(r)), r < 16 ? "R2 luma payload" : "R3 chroma payload",
                out_data, payload(mb, arrival_of(r)));
            chk(out_comp == (r < 16 ? 2'd0 : (r < 20 ? 2'd1 : 2'd2)), "R4 component tag",
                128'(out_comp), 128'(r < 16 ? 0 : (r < 20 ? 1 : 2)));
            chk(out_last == (r == 23), "R6 last flag", 128'(out_last), 128'(r == 23));
        end
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready after reset", 128'(in_ready), 128'd1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 128'(out_valid), 128'd0);
        chk(out_last == 1'b0, "R1 out_last after reset", 128'(out_last), 128'd0);
    endtask

    task automatic t_single();
        send_mb(1, 1'b1);
        collect_mb(1, 1'b0);
    endtask

    task automatic t_backpressure();
        send_mb(5, 1'b1);
        collect_mb(5, 1'b1);
    endtask

    task automatic t_two_banks();
        send_mb(2, 1'b0);
        send_mb(3, 1'b0);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R8 input held with both banks full", 128'(in_ready), 128'd0);
        chk(out_valid == 1'b1, "R8 output pending", 128'(out_valid), 128'd1);
        fork
            send_mb(4, 1'b0);
            begin
                collect_mb(2, 1'b0);
                collect_mb(3, 1'b0);
                collect_mb(4, 1'b0);
            end
        join
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_backpressure();
        t_two_banks();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule